// File: doc/BRIEF.md
# External Bus Yield Controller

This block decides when a processor's external bus interface hands the bus over to an outside master that has asked for it, and when it takes the bus back. It watches the start and end markers of each bus cycle issued by the internal memory controller, together with a flag that tags a cycle as a DRAM refresh. A handover happens only where one bus cycle ends. A request that arrives between cycles does not stop the next cycle from starting: that cycle runs to completion first. The boundary between a refresh cycle and the cycle that follows it is never used for a handover.

During the handover the block sequences three output-enable controls. Address and data drivers are switched off at once. The strobe drivers first hold their inactive high level for a set number of clocks and are then floated. Only after that does the acknowledge go high. When the request is withdrawn, the acknowledge drops and the drivers come back on with the strobes held inactive for a set number of clocks. Only then is the internal master allowed to issue cycles again. While the bus is away, the internal master is held by a stall output. A refresh request from the refresh timer is kept pending until the bus is back. The request input is asynchronous and goes through a synchronizer. All timing figures are in clock cycles.

Top module: `bus_yield_ctrl`

## Requirements
- R1: A handover is decided in the clock in which `cyc_end_i` is high, provided the synchronized request is high in that clock. A request raised in the gap between cycles therefore takes effect only at the end of the next cycle, which still starts and completes.
- R2: The request passes through a 2-flop synchronizer. If `ext_req_i` is driven high in clock n, it is first honored at a cycle end in clock n+2 or later. A cycle that ends earlier completes without a handover, and the handover slips to the following cycle end.
- R3: A cycle is a refresh cycle when `cyc_refresh_i` is high together with `cyc_start_i`. No handover is decided at the end of a refresh cycle. A pending request is served at the end of the cycle that follows it.
- R4: In the FLOATSTROBE_HI_CYC clocks (default 1) right after the deciding clock, `bus_oe_o`=0, `strobe_oe_o`=1, `strobe_hi_o`=1 and `bus_ack_o`=0.
- R5: After that phase, the bus stays released with `bus_oe_o`=0, `strobe_oe_o`=0 and `bus_ack_o`=1 for as long as the synchronized request stays high.
- R6: `stall_o` is high in the deciding clock itself (combinationally), and stays high through the strobe phase, the released phase and the reclaim phase. It is low in every other clock in which the bus is owned.
- R7: If `ext_req_i` is driven low in clock d, `bus_ack_o` is still 1 in clock d+2. In clock d+3, for RECLAIM_CYC clocks (default 1), it shows `bus_ack_o`=0, `bus_oe_o`=1, `strobe_oe_o`=1, `strobe_hi_o`=1 and `stall_o`=1. In the next clock `stall_o`=0 and `strobe_hi_o`=0.
- R8: A one-clock pulse on `refresh_req_i` in clock m produces a one-clock pulse on `refresh_go_o` in clock m+2 when the bus is owned and idle. A pulse that arrives while the bus is away is held, with `refresh_go_o`=0, and is issued in the clock after the block returns to idle.
- R9: A request withdrawn before any qualifying cycle end causes no handover: `bus_ack_o` stays 0 and later cycle ends leave `stall_o` low.
- R10: Synchronous active-high reset gives `bus_ack_o`=0, `stall_o`=0, `bus_oe_o`=1, `strobe_oe_o`=1, `strobe_hi_o`=0 and `refresh_go_o`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_req_i | input | 1 | Asynchronous bus request from the external master |
| cyc_start_i | input | 1 | First clock of an internal bus cycle |
| cyc_end_i | input | 1 | Last clock of an internal bus cycle |
| cyc_refresh_i | input | 1 | With cyc_start_i: the starting cycle is a refresh |
| refresh_req_i | input | 1 | Refresh request pulse from the refresh timer |
| bus_ack_o | output | 1 | Bus granted to the external master |
| stall_o | output | 1 | Internal master must not start a new cycle |
| bus_oe_o | output | 1 | Address and data driver enable |
| strobe_oe_o | output | 1 | Strobe driver enable |
| strobe_hi_o | output | 1 | Force strobes to the inactive high level |
| refresh_go_o | output | 1 | Pulse: a refresh cycle may be issued now |

## Verification
The hardest situation to reach from the ports is a request that becomes visible only after the synchronizer delay. It has to land inside or just beside a refresh cycle, so that the refresh rule and the setup slip combine. The bench drives a master model that issues cycles of fixed length with one-clock gaps. A table sets, for each run, which cycle is a refresh and the clock in which the request rises. The table places the request in gaps, at the exact setup limit, one clock late, and across refresh cycles. For each run the bench checks which cycle end produced the stall.

// File: rtl/bus_yield_pkg.sv
package bus_yield_pkg;
  typedef enum logic [2:0] {
    Y_IDLE_OWN      = 3'd0,
    Y_WAIT_BOUNDARY = 3'd1,
    Y_FLOAT_STROBES = 3'd2,
    Y_RELEASED      = 3'd3,
    Y_RECLAIM       = 3'd4
  } yield_state_t;
endpackage

// File: rtl/yield_req_sync.sv
module yield_req_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) chain_q[g] <= 1'b0;
        else if (g == 0) chain_q[g] <= async_i;
        else chain_q[g] <= chain_q[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/yield_ref_queue.sv
module yield_ref_queue (
  input  logic clk,
  input  logic rst,
  input  logic req_i,
  input  logic idle_i,
  output logic go_o
);
  logic pend_q, go_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      go_q   <= 1'b0;
    end else begin
      go_q   <= pend_q & idle_i;
      pend_q <= req_i | (pend_q & ~idle_i);
    end
  end

  assign go_o = go_q;

  AST_GO_ONLY_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    go_q |-> $past(idle_i));  // R8
  AST_HELD_WHILE_AWAY: assert property (@(posedge clk) disable iff (rst)
    !idle_i |=> !go_q);  // R8
endmodule

// File: rtl/yield_fsm.sv
module yield_fsm
  import bus_yield_pkg::*;
#(
  parameter int FLOAT_CYC   = 1,
  parameter int RECLAIM_CYC = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic req_s_i,
  input  logic cyc_start_i,
  input  logic cyc_end_i,
  input  logic cyc_refresh_i,
  output logic idle_o,
  output logic ack_o,
  output logic stall_o,
  output logic bus_oe_o,
  output logic strobe_oe_o,
  output logic strobe_hi_o
);
  localparam int MAXC = (FLOAT_CYC > RECLAIM_CYC) ? FLOAT_CYC : RECLAIM_CYC;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] FLOAT_LAST   = CW'(FLOAT_CYC - 1);
  localparam logic [CW-1:0] RECLAIM_LAST = CW'(RECLAIM_CYC - 1);

  yield_state_t state_q, state_d;
  logic [CW-1:0] cnt_q;
  logic in_ref_q, cur_ref, owned, boundary_ok;

  assign cur_ref     = in_ref_q | (cyc_start_i & cyc_refresh_i);
  assign owned       = (state_q == Y_IDLE_OWN) || (state_q == Y_WAIT_BOUNDARY);
  assign boundary_ok = owned & req_s_i & cyc_end_i & ~cur_ref;

  always_ff @(posedge clk) begin
    if (rst) in_ref_q <= 1'b0;
    else     in_ref_q <= cur_ref & ~cyc_end_i;
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      Y_IDLE_OWN, Y_WAIT_BOUNDARY: begin
        if (boundary_ok)  state_d = Y_FLOAT_STROBES;
        else if (req_s_i) state_d = Y_WAIT_BOUNDARY;
        else              state_d = Y_IDLE_OWN;
      end
      Y_FLOAT_STROBES: if (cnt_q == FLOAT_LAST)   state_d = Y_RELEASED;
      Y_RELEASED:      if (!req_s_i)              state_d = Y_RECLAIM;
      Y_RECLAIM:       if (cnt_q == RECLAIM_LAST) state_d = Y_IDLE_OWN;
      default:         state_d = Y_IDLE_OWN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= Y_IDLE_OWN;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      if (state_d != state_q) cnt_q <= '0;
      else if (state_q == Y_FLOAT_STROBES || state_q == Y_RECLAIM) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign idle_o      = (state_q == Y_IDLE_OWN);
  assign ack_o       = (state_q == Y_RELEASED);
  assign bus_oe_o    = owned || (state_q == Y_RECLAIM);
  assign strobe_oe_o = (state_q != Y_RELEASED);
  assign strobe_hi_o = (state_q == Y_FLOAT_STROBES) || (state_q == Y_RECLAIM);
  assign stall_o     = ~owned | boundary_ok;

  AST_NO_GRANT_WITHOUT_REQ: assert property (@(posedge clk) disable iff (rst)
    (owned && !req_s_i) |=> state_q != Y_FLOAT_STROBES);  // R1
  AST_NO_REFRESH_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
    (owned && cyc_end_i && cur_ref) |=> state_q != Y_FLOAT_STROBES);  // R3
  AST_ACK_AFTER_FLOAT: assert property (@(posedge clk) disable iff (rst)
    $rose(ack_o) |-> $past(state_q == Y_FLOAT_STROBES));  // R4
  AST_DROP_ON_WITHDRAW: assert property (@(posedge clk) disable iff (rst)
    (state_q == Y_RELEASED && !req_s_i) |=> (!ack_o && stall_o && bus_oe_o));  // R7
  AST_RESUME_AFTER_RECLAIM: assert property (@(posedge clk) disable iff (rst)
    $fell(stall_o) |-> $past(state_q == Y_RECLAIM));  // R6
endmodule

// File: rtl/bus_yield_ctrl.sv
module bus_yield_ctrl #(
  parameter int SYNC_STAGES = 2,
  parameter int FLOAT_CYC   = 1,
  parameter int RECLAIM_CYC = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic ext_req_i,
  input  logic cyc_start_i,
  input  logic cyc_end_i,
  input  logic cyc_refresh_i,
  input  logic refresh_req_i,
  output logic bus_ack_o,
  output logic stall_o,
  output logic bus_oe_o,
  output logic strobe_oe_o,
  output logic strobe_hi_o,
  output logic refresh_go_o
);
  logic req_s, idle;

  yield_req_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_i(ext_req_i), .sync_o(req_s)
  );

  yield_fsm #(.FLOAT_CYC(FLOAT_CYC), .RECLAIM_CYC(RECLAIM_CYC)) u_fsm (
    .clk(clk), .rst(rst), .req_s_i(req_s),
    .cyc_start_i(cyc_start_i), .cyc_end_i(cyc_end_i), .cyc_refresh_i(cyc_refresh_i),
    .idle_o(idle), .ack_o(bus_ack_o), .stall_o(stall_o),
    .bus_oe_o(bus_oe_o), .strobe_oe_o(strobe_oe_o), .strobe_hi_o(strobe_hi_o)
  );

  yield_ref_queue u_refq (
    .clk(clk), .rst(rst), .req_i(refresh_req_i), .idle_i(idle), .go_o(refresh_go_o)
  );
endmodule

// File: tb/test_bus_yield_ctrl.sv
module test_bus_yield_ctrl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ext_req = 1'b0, cyc_start = 1'b0, cyc_end = 1'b0, cyc_ref = 1'b0, ref_req = 1'b0;
  logic bus_ack, stall, bus_oe, strobe_oe, strobe_hi, ref_go;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  bus_yield_ctrl i_bus_yield_ctrl (
    .clk(clk), .rst(rst), .ext_req_i(ext_req), .cyc_start_i(cyc_start),
    .cyc_end_i(cyc_end), .cyc_refresh_i(cyc_ref), .refresh_req_i(ref_req),
    .bus_ack_o(bus_ack), .stall_o(stall), .bus_oe_o(bus_oe),
    .strobe_oe_o(strobe_oe), .strobe_hi_o(strobe_hi), .refresh_go_o(ref_go)
  );

  // row: {refresh mask of cycles 3..0, request rise clock, expected release cycle, tag}
  localparam int NROWS = 9;
  localparam logic [12:0] ROWS [NROWS] = '{
    {4'b0000, 4'd0, 3'd0, 2'd1},
    {4'b0000, 4'd3, 3'd1, 2'd1},
    {4'b0000, 4'd6, 3'd2, 2'd1},
    {4'b0000, 4'd1, 3'd1, 2'd2},
    {4'b0000, 4'd2, 3'd1, 2'd2},
    {4'b0000, 4'd4, 3'd1, 2'd2},
    {4'b0001, 4'd0, 3'd1, 2'd3},
    {4'b0010, 4'd1, 3'd2, 2'd3},
    {4'b0100, 4'd5, 3'd3, 2'd3}
  };

  function automatic string tagname(input int t);
    case (t)
      1: return "R1";
      2: return "R2";
      default: return "R3";
    endcase
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input logic rq, input logic st, input logic en, input logic rf, input logic rr);
    @(negedge clk);
    ext_req = rq; cyc_start = st; cyc_end = en; cyc_ref = rf; ref_req = rr;
    #5;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    step(0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0);
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, errors);
      $finish;
    end
  end

  initial begin
    // R10 reset state
    do_reset();
    step(0, 0, 0, 0, 0);
    check("R10 ack", bus_ack, 0);
    check("R10 stall", stall, 0);
    check("R10 bus_oe", bus_oe, 1);
    check("R10 strobe_oe", strobe_oe, 1);
    check("R10 strobe_hi", strobe_hi, 0);
    check("R10 refresh_go", ref_go, 0);

    // R8 refresh pulse while owned: go two clocks later
    step(0, 0, 0, 0, 1);
    step(0, 0, 0, 0, 0);
    check("R8 go early", ref_go, 0);
    step(0, 0, 0, 0, 0);
    check("R8 go idle", ref_go, 1);
    step(0, 0, 0, 0, 0);
    check("R8 go one pulse", ref_go, 0);

    // R9 request withdrawn before any cycle end
    for (int i = 0; i < 3; i++) step(1, 0, 0, 0, 0);
    for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 0);
    step(0, 1, 0, 0, 0);
    step(0, 0, 0, 0, 0);
    step(0, 0, 1, 0, 0);
    check("R9 stall at end", stall, 0);
    step(0, 0, 0, 0, 0);
    check("R9 ack", bus_ack, 0);
    check("R9 bus_oe", bus_oe, 1);

    // table-driven release runs
    for (int row = 0; row < NROWS; row++) begin
      logic [3:0] mask;
      int r, expk, rel;
      string tg;
      mask = ROWS[row][12:9];
      r    = int'(ROWS[row][8:5]);
      expk = int'(ROWS[row][4:2]);
      tg   = tagname(int'(ROWS[row][1:0]));
      rel  = -1;
      do_reset();
      for (int k = 0; k < 5; k++) begin
        for (int j = 0; j < 4; j++) begin
          if (rel < 0) begin
            step((4*k + j) >= r, j == 0, j == 2, (j == 0) && (k < 4) && mask[k[1:0]], 0);
            if (j == 2 && stall) rel = k;
          end
        end
      end
      check(tg, rel, expk);
      step(1, 0, 0, 0, 0);
      check("R4 ack", bus_ack, 0);
      check("R4 bus_oe", bus_oe, 0);
      check("R4 strobe_oe", strobe_oe, 1);
      check("R4 strobe_hi", strobe_hi, 1);
      check("R6 stall float", stall, 1);
      step(1, 0, 0, 0, 1);
      check("R5 ack", bus_ack, 1);
      check("R5 bus_oe", bus_oe, 0);
      check("R5 strobe_oe", strobe_oe, 0);
      check("R6 stall released", stall, 1);
      step(1, 0, 0, 0, 0);
      step(1, 0, 0, 0, 0);
      check("R8 held go", ref_go, 0);
      check("R5 ack hold", bus_ack, 1);
      step(0, 0, 0, 0, 0);
      step(0, 0, 0, 0, 0);
      step(0, 0, 0, 0, 0);
      check("R7 ack d+2", bus_ack, 1);
      step(0, 0, 0, 0, 0);
      check("R7 ack drop", bus_ack, 0);
      check("R7 bus_oe", bus_oe, 1);
      check("R7 strobe_oe", strobe_oe, 1);
      check("R7 strobe_hi", strobe_hi, 1);
      check("R7 stall", stall, 1);
      check("R8 go reclaim", ref_go, 0);
      step(0, 0, 0, 0, 0);
      check("R7 resume stall", stall, 0);
      check("R7 resume strobe_hi", strobe_hi, 0);
      check("R8 go not yet", ref_go, 0);
      step(0, 0, 0, 0, 0);
      check("R8 queued go", ref_go, 1);
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, errors);
    $finish;
  end
endmodule